// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block sits on a memory command/address path and re-times it. On each rising clock edge it captures a 22-bit command/address word together with two active-low chip selects, two clock-enable bits and two on-die-termination bits. Every captured bit leaves the block twice, as an A copy and a B copy, so that two loads can each be fed from their own register.

A mode strap chooses how the command word is handled. In gated mode the command word is loaded only on an edge where at least one chip select is low. When both chip selects are high, the previous word stays on the outputs, which saves switching power on the wide bus. In free-running mode the command word is loaded on every edge. The select, clock-enable and termination bits do not depend on the mode: they are loaded on every edge. An active-low reset, asynchronous to the clock, clears every register at once and overrides the gating.

Top module: `cmdreg_fanout`

## Requirements
- R1: With `gate_en` low, after every rising edge with reset released, `cmd_out_a` equals the `cmd_in` value sampled at that edge, whatever `cs_n_in` is.
- R2: With `gate_en` high, an edge where `cs_n_in` is 2'b01, 2'b10 or 2'b00 (at least one bit low) loads `cmd_in` into the command outputs.
- R3: With `gate_en` high, an edge where `cs_n_in` is 2'b11 leaves the command outputs unchanged, even if `cmd_in` differs.
- R4: `cs_n_out`, `cke_out` and `odt_out` take the values of `cs_n_in`, `cke_in` and `odt_in` on every rising edge with reset released, in both modes and whatever the chip selects are.
- R5: On every cycle each B output equals its A output bit for bit.
- R6: While `rst_n` is low every output is 0, and a falling `rst_n` clears the outputs without waiting for a clock edge.
- R7: Reset takes priority over the gating: clock edges during reset load nothing, even with a chip select low, and after release the command outputs hold 0 until a loading edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | Mode strap: 1 = chip-select gated command word, 0 = load every edge |
| cmd_in | input | 22 | Command/address word |
| cs_n_in | input | 2 | Chip selects, active low |
| cke_in | input | 2 | Clock-enable bits |
| odt_in | input | 2 | Termination-control bits |
| cmd_out_a | output | 22 | Registered command word, copy A |
| cmd_out_b | output | 22 | Registered command word, copy B |
| cs_n_out_a | output | 2 | Registered chip selects, copy A |
| cs_n_out_b | output | 2 | Registered chip selects, copy B |
| cke_out_a | output | 2 | Registered clock enables, copy A |
| cke_out_b | output | 2 | Registered clock enables, copy B |
| odt_out_a | output | 2 | Registered termination bits, copy A |
| odt_out_b | output | 2 | Registered termination bits, copy B |

## Verification
Directed edges walk all four chip-select codes in gated mode and show which of them load the command word. The idle code 2'b11 is then repeated in free-running mode, which separates a missing strap from an inverted select decode. A new command word is presented on each idle edge, so a hold cannot pass by chance. While the command word is held, the clock-enable and termination bits toggle, which shows they are never gated. Long random runs that mix both modes are checked against a bench model of the gating rule. A reset asserted in the middle of a cycle, and reset held across edges with a chip select low, check the asynchronous clear and its priority over the gating.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  // Number of identical output copies driven from each captured bit.
  parameter int unsigned NCOPY = 2;

  // Mode strap encoding.
  typedef enum logic {
    MODE_FREE  = 1'b0,
    MODE_GATED = 1'b1
  } gate_mode_e;

  // True when any active-low select in the vector is asserted.
  function automatic logic any_low(input logic [1:0] sel_n);
    return ~&sel_n;
  endfunction

endpackage

// File: rtl/cmdreg_gate_ctl.sv
module cmdreg_gate_ctl
  import cmdreg_pkg::*;
#(
  parameter int unsigned CS_W = 2
) (
  input  logic            gate_en,
  input  logic [CS_W-1:0] cs_n,
  output logic            cmd_load,
  output logic            ctl_load
);

  localparam int unsigned CS_PAD = (CS_W < 2) ? 2 : CS_W;

  gate_mode_e        mode;
  logic [CS_PAD-1:0] cs_pad;
  logic              sel_active;

  always_comb begin
    mode   = gate_mode_e'(gate_en);
    cs_pad = '1;
    cs_pad[CS_W-1:0] = cs_n;
  end

  generate
    if (CS_PAD == 2) begin : g_two_sel
      assign sel_active = any_low(cs_pad[1:0]);
    end else begin : g_many_sel
      assign sel_active = ~&cs_pad;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MODE_GATED: cmd_load = sel_active;
      default:    cmd_load = 1'b1;
    endcase
  end

  // Select, clock-enable and termination bits are never gated.
  assign ctl_load = 1'b1;

endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank #(
  parameter int unsigned W     = 22,
  parameter int unsigned NCOPY = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [W-1:0]              d,
  output logic [NCOPY-1:0][W-1:0]   q
);

  generate
    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      logic [W-1:0] r;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    r <= '0;
        else if (load) r <= d;
      end

      assign q[c] = r;

      if (c > 0) begin : g_cmp
        // R5: every copy matches copy 0
        p_copy_match_r5: assert property (@(posedge clk) q[c] == q[0])
          else $error("copy %0d differs from copy 0", c);
      end
    end
  endgenerate

  // R3: no load request leaves the bank unchanged
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q))
    else $error("bank changed without load");

  // R1: a load request captures the input
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q[0] == $past(d))
    else $error("bank did not capture input");

  // R6: reset forces zero
  p_reset_zero_r6: assert property (@(posedge clk) !rst_n |-> q == '0)
    else $error("bank not cleared in reset");

endmodule

// File: rtl/cmdreg_fanout.sv
module cmdreg_fanout
  import cmdreg_pkg::*;
#(
  parameter int unsigned CMD_W = 22,
  parameter int unsigned CS_W  = 2,
  parameter int unsigned CKE_W = 2,
  parameter int unsigned ODT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_en,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic [CS_W-1:0]  cs_n_in,
  input  logic [CKE_W-1:0] cke_in,
  input  logic [ODT_W-1:0] odt_in,
  output logic [CMD_W-1:0] cmd_out_a,
  output logic [CMD_W-1:0] cmd_out_b,
  output logic [CS_W-1:0]  cs_n_out_a,
  output logic [CS_W-1:0]  cs_n_out_b,
  output logic [CKE_W-1:0] cke_out_a,
  output logic [CKE_W-1:0] cke_out_b,
  output logic [ODT_W-1:0] odt_out_a,
  output logic [ODT_W-1:0] odt_out_b
);

  localparam int unsigned CTL_W = CS_W + CKE_W + ODT_W;

  logic                            cmd_load;
  logic                            ctl_load;
  logic [CTL_W-1:0]                ctl_d;
  logic [NCOPY-1:0][CMD_W-1:0]     cmd_q;
  logic [NCOPY-1:0][CTL_W-1:0]     ctl_q;

  cmdreg_gate_ctl #(.CS_W(CS_W)) u_gate (
    .gate_en  (gate_en),
    .cs_n     (cs_n_in),
    .cmd_load (cmd_load),
    .ctl_load (ctl_load)
  );

  cmdreg_bank #(.W(CMD_W), .NCOPY(NCOPY)) u_cmd_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_load),
    .d     (cmd_in),
    .q     (cmd_q)
  );

  assign ctl_d = {odt_in, cke_in, cs_n_in};

  cmdreg_bank #(.W(CTL_W), .NCOPY(NCOPY)) u_ctl_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctl_load),
    .d     (ctl_d),
    .q     (ctl_q)
  );

  assign cmd_out_a  = cmd_q[0];
  assign cmd_out_b  = cmd_q[NCOPY-1];
  assign cs_n_out_a = ctl_q[0][CS_W-1:0];
  assign cs_n_out_b = ctl_q[NCOPY-1][CS_W-1:0];
  assign cke_out_a  = ctl_q[0][CS_W +: CKE_W];
  assign cke_out_b  = ctl_q[NCOPY-1][CS_W +: CKE_W];
  assign odt_out_a  = ctl_q[0][CS_W+CKE_W +: ODT_W];
  assign odt_out_b  = ctl_q[NCOPY-1][CS_W+CKE_W +: ODT_W];

  // R1: free-running mode loads every edge
  p_free_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> cmd_out_a == $past(cmd_in))
    else $error("free mode missed a load");

  // R2: a low select loads in gated mode
  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !(&cs_n_in)) |=> cmd_out_b == $past(cmd_in))
    else $error("gated mode missed a selected load");

  // R3: both selects high hold the word in gated mode
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (&cs_n_in)) |=> $stable(cmd_out_a))
    else $error("gated mode changed while idle");

  // R4: control bits follow every edge
  p_ctl_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_n_out_a == $past(cs_n_in)) && (cke_out_b == $past(cke_in))
             && (odt_out_a == $past(odt_in)))
    else $error("control bits not re-registered");

  // R5: port copies agree
  p_port_copy_r5: assert property (@(posedge clk)
    (cmd_out_a == cmd_out_b) && (odt_out_a == odt_out_b))
    else $error("A and B ports differ");

  // R7: reset overrides a selected edge
  p_reset_prio_r7: assert property (@(posedge clk)
    (!rst_n && !(&cs_n_in)) |-> cmd_out_a == '0)
    else $error("load during reset");

endmodule

// File: tb/cmdreg_fanout_bench.sv
`timescale 1ns/1ps
module cmdreg_fanout_bench;

  localparam int CMD_W = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             gate_en = 1'b0;
  logic [CMD_W-1:0] cmd_in = '0;
  logic [1:0]       cs_n_in = 2'b11;
  logic [1:0]       cke_in = '0;
  logic [1:0]       odt_in = '0;
  logic [CMD_W-1:0] cmd_out_a, cmd_out_b;
  logic [1:0]       cs_n_out_a, cs_n_out_b, cke_out_a, cke_out_b, odt_out_a, odt_out_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [CMD_W-1:0] exp_cmd = '0;
  logic [1:0]       exp_cs = '0, exp_cke = '0, exp_odt = '0;

  always #2.5 clk = ~clk;

  cmdreg_fanout u_cmdreg_fanout (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cmd_in(cmd_in),
    .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in),
    .cmd_out_a(cmd_out_a), .cmd_out_b(cmd_out_b),
    .cs_n_out_a(cs_n_out_a), .cs_n_out_b(cs_n_out_b),
    .cke_out_a(cke_out_a), .cke_out_b(cke_out_b),
    .odt_out_a(odt_out_a), .odt_out_b(odt_out_b)
  );

  function automatic logic expect_load(input logic ge, input logic [1:0] cs);
    return !ge || (cs != 2'b11);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic verify(input string tag);
    chk(tag, 32'(cmd_out_a), 32'(exp_cmd));
    chk("R5", 32'(cmd_out_b), 32'(cmd_out_a));
    chk("R4", {26'd0, odt_out_a, cke_out_a, cs_n_out_a}, {26'd0, exp_odt, exp_cke, exp_cs});
    chk("R5", {26'd0, odt_out_b, cke_out_b, cs_n_out_b}, {26'd0, odt_out_a, cke_out_a, cs_n_out_a});
  endtask

  // Called just after a falling edge; checks after the next falling edge.
  task automatic step(input logic [CMD_W-1:0] c, input logic [1:0] cs,
                      input logic [1:0] ke, input logic [1:0] ot,
                      input logic ge, input string tag);
    cmd_in = c; cs_n_in = cs; cke_in = ke; odt_in = ot; gate_en = ge;
    @(posedge clk);
    if (rst_n) begin
      if (expect_load(ge, cs)) exp_cmd = c;
      exp_cs = cs; exp_cke = ke; exp_odt = ot;
    end
    @(negedge clk);
    verify(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R6", {8'd0, cmd_out_a, odt_out_b, cs_n_out_a}, 32'd0);
    // R7: edges during reset with selects low load nothing
    step(22'h2ABCDE, 2'b00, 2'b11, 2'b11, 1'b0, "R7");
    rst_n = 1'b1;
    // R7: after release, idle gated edge keeps zero
    step(22'h155555, 2'b11, 2'b01, 2'b10, 1'b1, "R7");
    // R1: free mode loads with both selects high
    step(22'h3FFFFF, 2'b11, 2'b10, 2'b01, 1'b0, "R1");
    step(22'h012345, 2'b11, 2'b00, 2'b11, 1'b0, "R1");
    // R2: each active select code loads in gated mode
    step(22'h0A0A0A, 2'b10, 2'b11, 2'b00, 1'b1, "R2");
    step(22'h050505, 2'b01, 2'b01, 2'b01, 1'b1, "R2");
    step(22'h3C3C3C, 2'b00, 2'b10, 2'b10, 1'b1, "R2");
    // R3: idle in gated mode holds while new words arrive; R4 bits still toggle
    step(22'h000001, 2'b11, 2'b01, 2'b10, 1'b1, "R3");
    step(22'h2FFFFE, 2'b11, 2'b10, 2'b01, 1'b1, "R3");
    step(22'h123456, 2'b11, 2'b11, 2'b11, 1'b1, "R4");
    // Random mix of both modes
    for (int i = 0; i < 400; i++) begin
      logic ge;
      ge = ($urandom % 4) != 0;
      step(CMD_W'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), ge,
           ge ? "R2/R3" : "R1");
    end
    // R6: asynchronous clear in mid-cycle
    step(22'h3ABCDE, 2'b00, 2'b11, 2'b11, 1'b0, "R1");
    #1 rst_n = 1'b0;
    #0.5;
    chk("R6", 32'(cmd_out_a), 32'd0);
    chk("R6", {26'd0, odt_out_a, cke_out_a, cs_n_out_a}, 32'd0);
    exp_cmd = '0; exp_cs = '0; exp_cke = '0; exp_odt = '0;
    @(negedge clk);
    step(22'h1F1F1F, 2'b10, 2'b11, 2'b11, 1'b1, "R7");
    step(22'h2E2E2E, 2'b01, 2'b11, 2'b11, 1'b0, "R7");
    rst_n = 1'b1;
    step(22'h111111, 2'b10, 2'b01, 2'b01, 1'b1, "R2");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule